// File: doc/BRIEF.md
# Clock Controller Configuration Register Bank

This block holds the 32-bit configuration words of a clock control unit and makes them available over a simple word-wide bus. The bus is a byte address, a write strobe, a read strobe, write data and registered read data. Each word comes out of reset with its own fixed value. A write to a word is filtered through that word's writable-bit mask, and one word has a bit that stays set after every write. Most words are read-only, so writes to them are dropped.

The whole register file is also driven out continuously as one flat vector. A separate clock-frequency calculator reads it to find PLL settings, dividers and gating state. A one-cycle error pulse marks any access the bank refuses: a misaligned address, an index with no register behind it, or a write to a read-only word.

The bank has 28 word slots, at indices 0 to 27. Indices 26 and 27 are reserved and read as zero.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset the words hold these values, by index: 0=0x074b0b7d, 1=0xff870b48, 2=0x49fcfe7f, 3=0x007f0000, 4=0x04001800, 5=0x04051c03, 6=0x04043001, 7=0x00000280, 8/9/10/11=0xffffffff, 18=0x00004040, 23=0x80209828, 24=0x00aa0000, 25=0x00000285, and every other index (12-17, 19-22, 26, 27) = 0. After reset, `bus_rdata` = 0 and `bus_err` = 0.
- R2: The word index is the 12-bit byte address `bus_addr` shifted right by two, so index n sits at byte address 4n. Indices 28 to 1023 have no register behind them.
- R3: A write to index 0 stores (data AND 0x3b6fdfff) OR 0x04000000, so bit 26 of word 0 always reads as 1.
- R4: A write to index 1 stores data AND 0xff9f3fff. A write to index 4 or to index 6 stores data AND 0xbfff3fff.
- R5: A write to index 2, 8, 9 or 10 stores all 32 bits of the write data.
- R6: A write to any other index changes no word and raises `bus_err`. This covers the read-only indices 3, 5, 7 and 11-27 and the unimplemented indices 28-1023.
- R7: A read of an index of 28 or more returns 0 and raises `bus_err`. `bus_err` is high for exactly the one cycle after an offending strobe and is low after every accepted access or idle cycle.
- R8: `bus_rdata` is registered. It presents the addressed word in the cycle after the read strobe and holds that value until the next read.
- R9: `cfg_words` carries word i on bits [32i+31:32i]. It shows the new value in the cycle after an accepted write.
- R10: An access whose address is not a multiple of 4 (`bus_addr[1:0]` != 0) is refused. A write changes no word, a read returns 0, and both raise `bus_err`.
- R11: When `bus_wr` and `bus_rd` are high together, the write is performed and the read is ignored, so `bus_rdata` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse marking a refused access |
| cfg_words | output | 896 | All 28 words, word i at bits [32i+31:32i] |

## Verification
Every stored bit is visible on `cfg_words` one cycle after it changes. A mask that is too wide or too narrow, a lost forced bit, or a read-only word that accepts a write therefore shows up at the next clock edge. A wrong reset value shows up in the first cycle after reset. Errors in decode or in the read path appear on `bus_rdata` or `bus_err` in the cycle after the strobe. The bench compares all outputs against its reference model on every clock, so a fault of this kind is reported at the cycle where it first shows.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int CK_NREG = 28;
  localparam int CK_DW   = 32;
  localparam int CK_AW   = 12;

  typedef logic [CK_DW-1:0] word_t;

  // Value each slot loads on reset
  function automatic word_t reg_reset(input int idx);
    case (idx)
      0:        reg_reset = 32'h074b0b7d;
      1:        reg_reset = 32'hff870b48;
      2:        reg_reset = 32'h49fcfe7f;
      3:        reg_reset = 32'h007f0000;
      4:        reg_reset = 32'h04001800;
      5:        reg_reset = 32'h04051c03;
      6:        reg_reset = 32'h04043001;
      7:        reg_reset = 32'h00000280;
      8, 9, 10, 11: reg_reset = 32'hffffffff;
      18:       reg_reset = 32'h00004040;
      23:       reg_reset = 32'h80209828;
      24:       reg_reset = 32'h00aa0000;
      25:       reg_reset = 32'h00000285;
      default:  reg_reset = '0;
    endcase
  endfunction

  // Bits a write may change; zero marks a read-only slot
  function automatic word_t reg_wmask(input int idx);
    case (idx)
      0:           reg_wmask = 32'h3b6fdfff;
      1:           reg_wmask = 32'hff9f3fff;
      4, 6:        reg_wmask = 32'hbfff3fff;
      2, 8, 9, 10: reg_wmask = 32'hffffffff;
      default:     reg_wmask = '0;
    endcase
  endfunction

  // Bits set by every accepted write
  function automatic word_t reg_force(input int idx);
    reg_force = (idx == 0) ? 32'h04000000 : '0;
  endfunction
endpackage

// File: rtl/clkctl_decode.sv
module clkctl_decode #(
  parameter int AW   = 12,
  parameter int NREG = 28,
  localparam int IW  = AW - 2
) (
  input  logic [AW-1:0] addr,
  output logic [IW-1:0] idx,
  output logic          in_range,
  output logic          aligned
);
  always_comb begin
    idx      = addr[AW-1:2];
    aligned  = (addr[1:0] == 2'b00);
    in_range = (int'(addr[AW-1:2]) < NREG);
  end
endmodule

// File: rtl/clkctl_word.sv
module clkctl_word #(
  parameter int          DW    = 32,
  parameter logic [DW-1:0] RSTV  = '0,
  parameter logic [DW-1:0] WMASK = '0,
  parameter logic [DW-1:0] FORCE = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q,
  output logic          accepts
);
  localparam bit WRITABLE = (WMASK != '0);

  assign accepts = we && WRITABLE;

  always_ff @(posedge clk) begin
    if (rst)
      q <= RSTV;
    else if (accepts)
      q <= (wdata & WMASK) | FORCE;
  end
endmodule

// File: rtl/clkctl_rdport.sv
module clkctl_rdport #(
  parameter int NREG = 28,
  parameter int DW   = 32,
  parameter int IW   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic               rd_ok,
  input  logic [IW-1:0]      idx,
  input  logic [NREG*DW-1:0] words,
  output logic [DW-1:0]      rdata
);
  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NREG; i++)
      if (int'(idx) == i) sel = words[i*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_ok ? sel : '0;
  end
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
  import clkctl_pkg::*;
#(
  parameter int NREG = CK_NREG,
  parameter int DW   = CK_DW,
  parameter int AW   = CK_AW,
  localparam int IW  = AW - 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               bus_err,
  output logic [NREG*DW-1:0] cfg_words
);
  logic [IW-1:0]   idx;
  logic            in_range, aligned, addr_ok;
  logic            acc_wr, acc_rd;
  logic [NREG-1:0] hit, taken;

  clkctl_decode #(.AW(AW), .NREG(NREG)) u_dec (
    .addr(bus_addr), .idx(idx), .in_range(in_range), .aligned(aligned)
  );

  assign addr_ok = in_range && aligned;
  assign acc_wr  = bus_wr;
  assign acc_rd  = bus_rd && !bus_wr;

  for (genvar i = 0; i < NREG; i++) begin : g_word
    assign hit[i] = acc_wr && addr_ok && (int'(idx) == i);
    clkctl_word #(
      .DW(DW), .RSTV(DW'(reg_reset(i))),
      .WMASK(DW'(reg_wmask(i))), .FORCE(DW'(reg_force(i)))
    ) u_word (
      .clk(clk), .rst(rst), .we(hit[i]), .wdata(bus_wdata),
      .q(cfg_words[i*DW +: DW]), .accepts(taken[i])
    );
  end

  clkctl_rdport #(.NREG(NREG), .DW(DW), .IW(IW)) u_rd (
    .clk(clk), .rst(rst), .rd_en(acc_rd), .rd_ok(addr_ok),
    .idx(idx), .words(cfg_words), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst)
      bus_err <= 1'b0;
    else
      bus_err <= (acc_wr && !(|taken)) || (acc_rd && !addr_ok);
  end
endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk #(
  parameter int NREG = 28,
  parameter int DW   = 32,
  parameter int AW   = 12
) (
  input logic               clk,
  input logic               rst,
  input logic [AW-1:0]      bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [DW-1:0]      bus_wdata,
  input logic [DW-1:0]      bus_rdata,
  input logic               bus_err,
  input logic [NREG*DW-1:0] cfg_words
);
  logic bad_rd;
  assign bad_rd = bus_rd && !bus_wr && (int'(bus_addr[AW-1:2]) >= NREG);

  AST_FORCED_BIT: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> cfg_words[26]);  // R3
  AST_MASK_IDX4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(16)) |=> cfg_words[4*DW +: DW] == ($past(bus_wdata) & 32'hbfff3fff));  // R4
  AST_FULL_IDX2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(8)) |=> cfg_words[2*DW +: DW] == $past(bus_wdata));  // R5
  AST_RO_STABLE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(cfg_words[3*DW +: DW]));  // R6
  AST_BAD_RD_ERR: assert property (@(posedge clk) disable iff (rst)
    bad_rd |=> (bus_err && bus_rdata == '0));  // R7
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr || bus_rd) |=> !bus_err);  // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && !bus_wr) |=> $stable(bus_rdata));  // R8
endmodule

bind clkctl_regbank clkctl_regbank_chk #(.NREG(NREG), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
  .cfg_words(cfg_words)
);

// File: tb/test_clkctl_regbank.sv
module test_clkctl_regbank;
  localparam int PERIOD = 10;
  localparam int N = 28;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_err;
  logic [N*32-1:0] cfg_words;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  clkctl_regbank i_clkctl_regbank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .cfg_words(cfg_words)
  );

  // Requirement tables (R1, R3, R4, R5)
  function automatic logic [31:0] exp_rst(input int i);
    logic [31:0] t[int];
    t[0] = 32'h074b0b7d; t[1] = 32'hff870b48; t[2] = 32'h49fcfe7f;
    t[3] = 32'h007f0000; t[4] = 32'h04001800; t[5] = 32'h04051c03;
    t[6] = 32'h04043001; t[7] = 32'h00000280; t[8] = '1; t[9] = '1;
    t[10] = '1; t[11] = '1; t[18] = 32'h00004040; t[23] = 32'h80209828;
    t[24] = 32'h00aa0000; t[25] = 32'h00000285;
    return t.exists(i) ? t[i] : 32'h0;
  endfunction

  function automatic logic [31:0] exp_mask(input int i);
    if (i == 0) return 32'h3b6fdfff;
    if (i == 1) return 32'hff9f3fff;
    if (i == 4 || i == 6) return 32'hbfff3fff;
    if (i == 2 || i == 8 || i == 9 || i == 10) return 32'hffffffff;
    return 32'h0;
  endfunction

  // Reference model, updated on each rising edge
  logic [31:0] m_reg [N];
  logic [31:0] m_rdata;
  logic m_err;
  bit m_live = 0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) m_reg[i] = exp_rst(i);
      m_rdata = 0; m_err = 0; m_live = 1;
    end else begin
      int ix;
      bit ok;
      ix = int'(bus_addr >> 2);
      ok = (bus_addr[1:0] == 0) && ix < N;
      m_err = 0;
      if (bus_wr) begin
        if (ok && exp_mask(ix) != 0)
          m_reg[ix] = (bus_wdata & exp_mask(ix)) | (ix == 0 ? 32'h04000000 : 32'h0);
        else
          m_err = 1;
      end else if (bus_rd) begin
        m_rdata = ok ? m_reg[ix] : 32'h0;
        if (!ok) m_err = 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && m_live && !done) begin
      for (int i = 0; i < N; i++)
        if (cfg_words[i*32 +: 32] !== m_reg[i])
          chk($sformatf("R9 word %0d", i), cfg_words[i*32 +: 32], m_reg[i]);
      chk("R8 model rdata", bus_rdata, m_rdata);
      chk("R7 model err", {31'b0, bus_err}, {31'b0, m_err});
    end
  end

  task automatic acc(input logic w, input logic r, input logic [11:0] a, input logic [31:0] d);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  function automatic logic [31:0] word(input int i);
    return cfg_words[i*32 +: 32];
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 word0", word(0), 32'h074b0b7d);
    chk("R1 word1", word(1), 32'hff870b48);
    chk("R1 word18", word(18), 32'h00004040);
    chk("R1 word25", word(25), 32'h00000285);
    chk("R1 word27", word(27), 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 err", {31'b0, bus_err}, 32'h0);
    // R8, R2 reads
    acc(0, 1, 12'h000, 0);
    chk("R8 read idx0", bus_rdata, 32'h074b0b7d);
    acc(0, 1, 12'h05c, 0);
    chk("R2 read idx23", bus_rdata, 32'h80209828);
    @(negedge clk);
    chk("R8 hold", bus_rdata, 32'h80209828);
    // R3
    acc(1, 0, 12'h000, 32'hffffffff);
    chk("R3 all ones", word(0), 32'h3f6fdfff);
    acc(1, 0, 12'h000, 32'h0);
    chk("R3 zero keeps bit26", word(0), 32'h04000000);
    // R4
    acc(1, 0, 12'h004, 32'hffffffff);
    chk("R4 idx1", word(1), 32'hff9f3fff);
    acc(1, 0, 12'h010, 32'hffffffff);
    chk("R4 idx4", word(4), 32'hbfff3fff);
    acc(1, 0, 12'h018, 32'h12345678);
    chk("R4 idx6", word(6), 32'h12341678);
    // R5
    acc(1, 0, 12'h008, 32'ha5a5a5a5);
    chk("R5 idx2", word(2), 32'ha5a5a5a5);
    acc(1, 0, 12'h024, 32'h0);
    chk("R5 idx9", word(9), 32'h0);
    chk("R5 err low", {31'b0, bus_err}, 32'h0);
    // R9 through read port
    acc(1, 0, 12'h028, 32'hdeadbeef);
    chk("R9 idx10 vector", word(10), 32'hdeadbeef);
    acc(0, 1, 12'h028, 0);
    chk("R9 idx10 read", bus_rdata, 32'hdeadbeef);
    // R6
    acc(1, 0, 12'h00c, 32'h0);
    chk("R6 idx3 kept", word(3), 32'h007f0000);
    chk("R6 idx3 err", {31'b0, bus_err}, 32'h1);
    acc(1, 0, 12'h014, 32'h0);
    chk("R6 idx5 kept", word(5), 32'h04051c03);
    acc(1, 0, 12'h070, 32'h0);
    chk("R6 idx28 err", {31'b0, bus_err}, 32'h1);
    @(negedge clk);
    chk("R7 err one cycle", {31'b0, bus_err}, 32'h0);
    // R7
    acc(0, 1, 12'h070, 0);
    chk("R7 oor read zero", bus_rdata, 32'h0);
    chk("R7 oor read err", {31'b0, bus_err}, 32'h1);
    acc(0, 1, 12'hffc, 0);
    chk("R7 top read err", {31'b0, bus_err}, 32'h1);
    // R10
    acc(1, 0, 12'h002, 32'h0);
    chk("R10 misaligned write kept", word(0), 32'h04000000);
    chk("R10 misaligned write err", {31'b0, bus_err}, 32'h1);
    acc(0, 1, 12'h000, 0);
    acc(0, 1, 12'h005, 0);
    chk("R10 misaligned read zero", bus_rdata, 32'h0);
    chk("R10 misaligned read err", {31'b0, bus_err}, 32'h1);
    // R11
    acc(0, 1, 12'h07c, 0);
    acc(1, 1, 12'h020, 32'h0);
    chk("R11 write done", word(8), 32'h0);
    chk("R11 rdata held", bus_rdata, 32'h0);
    acc(0, 1, 12'h060, 0);
    acc(1, 1, 12'h004, 32'h0);
    chk("R11 rdata held nonzero", bus_rdata, 32'h00aa0000);
    chk("R11 idx1 written", word(1), 32'h0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule